// File: doc/BRIEF.md
# Delayed Branch Sequencer

This block sits beside a processor's program counter and handles conditional branches that have three delay slots. When a branch issues and its condition holds, the block computes and stores the destination. It then counts retired instructions and redirects the program counter only after the branch itself and the three instructions behind it have retired. The condition is resolved when the branch issues. Later changes to the flag input or to the current PC therefore cannot alter where, or whether, the branch goes.

The branch arrives on a valid/ready port. `issue_ready` is high whenever no branch is outstanding. While a branch is pending, `issue_ready` is low, and a branch presented on `issue_valid` in that state is dropped and never taken. There is no queue. Results leave on plain strobes: `redirect` for an ordinary branch, or `loop_enter` when the delayed instruction was a block-repeat form, which hands control to the repeat-loop logic instead of jumping.

Top module: `dbr_seq`

## Requirements
- R1: After reset, `pending`, `redirect` and `loop_enter` are 0, `redirect_pc` is 0 and `issue_ready` is 1.
- R2: With `rel_mode`=0 (register mode), the redirect address equals `operand` as it was in the accepted issue cycle.
- R3: With `rel_mode`=1 (PC-relative), the redirect address is `pc` + sign-extended `operand[DW-1:0]` + 3, modulo 2^AW, using `pc` from the issue cycle.
- R4: `cond_sel`=0 selects the unconditional form, which is always taken. `cond_sel`=1 selects the greater-or-equal form, which is taken only when `n_flag` is 0 in the issue cycle.
- R5: A branch that is not taken leaves `pending` at 0, keeps `issue_ready` at 1 and never produces `redirect` or `loop_enter`.
- R6: A taken branch raises `pending` from the cycle after issue. Retire strobes are counted from the cycle after issue, and the first one counted is the branch's own. On the edge that samples the fourth counted retire strobe, `pending` drops and a one-cycle completion strobe appears.
- R7: Cycles with `retire` low do not advance the slot count. `pending` stays high across such stalls.
- R8: Changes to `n_flag`, `pc` or `operand` after the issue cycle do not change the outcome or the redirect address.
- R9: `issue_ready` is 0 while `pending` is 1. An issue presented then is dropped: the first branch keeps its target and timing, and no extra strobe appears.
- R10: When `is_block_rpt` was 1 at issue, completion pulses `loop_enter` instead of `redirect`.
- R11: `redirect` and `loop_enter` are never high together, and each taken branch yields exactly one single-cycle strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_valid | input | 1 | A delayed branch is presented |
| issue_ready | output | 1 | High when a branch can be accepted |
| cond_sel | input | 1 | 0 = unconditional, 1 = greater-or-equal (N clear) |
| n_flag | input | 1 | Negative flag at issue time |
| rel_mode | input | 1 | 0 = register target, 1 = PC-relative |
| is_block_rpt | input | 1 | Branch is the block-repeat delayed form |
| operand | input | AW | Register value, or displacement in low DW bits |
| pc | input | AW | Address of the branch instruction |
| retire | input | 1 | One instruction retired this cycle |
| redirect | output | 1 | One-cycle strobe: load `redirect_pc` into PC |
| redirect_pc | output | AW | Stored branch target |
| loop_enter | output | 1 | One-cycle strobe: enter the repeat-loop check |
| pending | output | 1 | A taken branch is waiting out its delay slots |

## Verification
The bench hunts for off-by-one slot counting. A design that counts the issue cycle, or that stops at three retires, would pulse one strobe early, and a design that counts idle cycles would fire during stalls; both show up as cycle mismatches in the scoreboard. A negative displacement exposes missing sign extension or a missing +3 through a wrong address. A second issue sent mid-delay, together with a flipped N flag and a moved PC, catches designs that re-evaluate late or overwrite the stored target, and a block-repeat branch catches designs that jump instead of handing over to the loop logic.

// File: rtl/dbr_pkg.sv
package dbr_pkg;

  typedef enum logic {
    COND_ALWAYS = 1'b0,
    COND_GE     = 1'b1
  } dbr_cond_e;

  typedef enum logic {
    MODE_REG = 1'b0,
    MODE_REL = 1'b1
  } dbr_mode_e;

endpackage

// File: rtl/dbr_cond.sv
module dbr_cond
  import dbr_pkg::*;
(
  input  logic cond_sel,
  input  logic n_flag,
  output logic take
);

  dbr_cond_e sel;

  always_comb begin
    sel = dbr_cond_e'(cond_sel);
    case (sel)
      COND_ALWAYS: take = 1'b1;
      COND_GE:     take = ~n_flag;
      default:     take = 1'b0;
    endcase
  end

endmodule

// File: rtl/dbr_target.sv
module dbr_target
  import dbr_pkg::*;
#(
  parameter int AW    = 24,
  parameter int DW    = 16,
  parameter int SLOTS = 3
) (
  input  logic          rel_mode,
  input  logic [AW-1:0] operand,
  input  logic [AW-1:0] pc,
  output logic [AW-1:0] target
);

  localparam logic [AW-1:0] PC_ADV = AW'(SLOTS);

  logic [AW-1:0] disp_ext;

  generate
    if (DW < AW) begin : g_sext
      assign disp_ext = {{(AW-DW){operand[DW-1]}}, operand[DW-1:0]};
    end else begin : g_full
      assign disp_ext = operand;
    end
  endgenerate

  always_comb begin
    if (dbr_mode_e'(rel_mode) == MODE_REL)
      target = pc + disp_ext + PC_ADV;
    else
      target = operand;
  end

endmodule

// File: rtl/dbr_slot_ctr.sv
module dbr_slot_ctr #(
  parameter int SLOTS = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic retire,
  output logic pending,
  output logic done
);

  localparam int CW = $clog2(SLOTS + 1);
  localparam logic [CW-1:0] LAST = CW'(SLOTS);

  logic [CW-1:0] cnt_q;
  logic          pend_q;

  assign pending = pend_q;
  assign done    = pend_q & retire & (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      cnt_q  <= '0;
    end else if (arm && !pend_q) begin
      pend_q <= 1'b1;
      cnt_q  <= '0;
    end else if (pend_q && retire) begin
      if (cnt_q == LAST) begin
        pend_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  p_cnt_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |-> (cnt_q <= LAST));

  p_stall_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !retire) |=> (pend_q && $stable(cnt_q)));

  p_last_slot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && retire && cnt_q == LAST) |=> !pend_q);

endmodule

// File: rtl/dbr_seq.sv
module dbr_seq #(
  parameter int AW    = 24,
  parameter int DW    = 16,
  parameter int SLOTS = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          issue_valid,
  output logic          issue_ready,
  input  logic          cond_sel,
  input  logic          n_flag,
  input  logic          rel_mode,
  input  logic          is_block_rpt,
  input  logic [AW-1:0] operand,
  input  logic [AW-1:0] pc,
  input  logic          retire,
  output logic          redirect,
  output logic [AW-1:0] redirect_pc,
  output logic          loop_enter,
  output logic          pending
);

  logic          take;
  logic          accept;
  logic          arm;
  logic          done;
  logic [AW-1:0] calc_tgt;
  logic [AW-1:0] tgt_q;
  logic          rpt_q;
  logic          redir_q;
  logic          loop_q;

  dbr_cond u_cond (
    .cond_sel (cond_sel),
    .n_flag   (n_flag),
    .take     (take)
  );

  dbr_target #(.AW(AW), .DW(DW), .SLOTS(SLOTS)) u_target (
    .rel_mode (rel_mode),
    .operand  (operand),
    .pc       (pc),
    .target   (calc_tgt)
  );

  dbr_slot_ctr #(.SLOTS(SLOTS)) u_ctr (
    .clk     (clk),
    .rst_n   (rst_n),
    .arm     (arm),
    .retire  (retire),
    .pending (pending),
    .done    (done)
  );

  assign issue_ready = ~pending;
  assign accept      = issue_valid & issue_ready;
  assign arm         = accept & take;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tgt_q   <= '0;
      rpt_q   <= 1'b0;
      redir_q <= 1'b0;
      loop_q  <= 1'b0;
    end else begin
      if (arm) begin
        tgt_q <= calc_tgt;
        rpt_q <= is_block_rpt;
      end
      redir_q <= done & ~rpt_q;
      loop_q  <= done & rpt_q;
    end
  end

  assign redirect    = redir_q;
  assign loop_enter  = loop_q;
  assign redirect_pc = tgt_q;

  p_ready_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pending |-> !issue_ready);

  p_untaken_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && issue_ready && !take) |=> !pending);

  p_hold_target_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pending |=> $stable(tgt_q));

  p_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(redir_q && loop_q));

  p_one_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (redir_q || loop_q) |=> !(redir_q || loop_q));

endmodule

// File: tb/dbr_seq_bench.sv
module dbr_seq_bench;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 24;
  localparam int DW = 16;
  localparam int SLOTS = 3;

  typedef struct {
    bit            is_loop;
    logic [AW-1:0] tgt;
    int            cyc;
    string         tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic issue_valid = 1'b0;
  logic issue_ready;
  logic cond_sel = 1'b0;
  logic n_flag = 1'b0;
  logic rel_mode = 1'b0;
  logic is_block_rpt = 1'b0;
  logic [AW-1:0] operand = '0;
  logic [AW-1:0] pc = '0;
  logic retire = 1'b0;
  logic redirect;
  logic [AW-1:0] redirect_pc;
  logic loop_enter;
  logic pending;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  bit done_flag = 1'b0;

  exp_t sb[$];
  bit   armed = 1'b0;
  int   exp_cnt = 0;
  exp_t cur;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  dbr_seq #(.AW(AW), .DW(DW), .SLOTS(SLOTS)) u_dbr_seq (
    .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .issue_ready(issue_ready),
    .cond_sel(cond_sel), .n_flag(n_flag), .rel_mode(rel_mode),
    .is_block_rpt(is_block_rpt), .operand(operand), .pc(pc), .retire(retire),
    .redirect(redirect), .redirect_pc(redirect_pc), .loop_enter(loop_enter),
    .pending(pending)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Monitor: pops expectations when a completion strobe shows up
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && (redirect || loop_enter)) begin
        chk(!(redirect && loop_enter), "R11 strobes exclusive", {redirect, loop_enter}, 0);
        if (sb.size() == 0) begin
          chk(1'b0, "R5/R9 unexpected strobe", {redirect, loop_enter}, 0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          chk(cyc == e.cyc, {e.tag, " R6 strobe cycle"}, cyc, e.cyc);
          chk(loop_enter == e.is_loop, {e.tag, " R10 strobe kind"}, loop_enter, e.is_loop);
          chk(redirect_pc == e.tgt, {e.tag, " target"}, redirect_pc, e.tgt);
          chk(pending == 1'b0, "R6 pending drops at completion", pending, 0);
        end
      end
    end
  end

  task automatic tick(input bit r);
    retire = r;
    if (r && armed) begin
      exp_cnt++;
      if (exp_cnt == SLOTS + 1) begin
        cur.cyc = cyc + 1;
        sb.push_back(cur);
        armed = 1'b0;
      end
    end
    @(negedge clk);
    retire = 1'b0;
  endtask

  task automatic send(input bit csel, input bit n, input bit rel, input bit rpt,
                      input logic [AW-1:0] op, input logic [AW-1:0] p,
                      input bit exp_take, input logic [AW-1:0] exp_tgt, input string tag);
    chk(issue_ready == 1'b1, {tag, " R9 ready when idle"}, issue_ready, 1);
    issue_valid = 1'b1; cond_sel = csel; n_flag = n; rel_mode = rel;
    is_block_rpt = rpt; operand = op; pc = p; retire = 1'b0;
    @(negedge clk);
    issue_valid = 1'b0;
    chk(pending == exp_take, {tag, exp_take ? " R6 pending after issue" : " R5 no pending"},
        pending, exp_take);
    if (exp_take) begin
      armed = 1'b1; exp_cnt = 0;
      cur.is_loop = rpt; cur.tgt = exp_tgt; cur.tag = tag;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(pending == 0, "R1 pending", pending, 0);
    chk(issue_ready == 1, "R1 ready", issue_ready, 1);
    chk(redirect == 0 && loop_enter == 0, "R1 strobes", {redirect, loop_enter}, 0);
    chk(redirect_pc == 0, "R1 target", redirect_pc, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 + R4: register mode, unconditional with N set
    send(1'b0, 1'b1, 1'b0, 1'b0, 24'h00ABCD, 24'h000100, 1'b1, 24'h00ABCD, "R2 R4 reg/always");
    for (int i = 0; i < 4; i++) tick(1'b1);
    repeat (2) tick(1'b0);

    // R3 + R7: PC-relative positive displacement with stalls
    send(1'b0, 1'b0, 1'b1, 1'b0, 24'h000010, 24'h000123, 1'b1, 24'h000136, "R3 R7 rel+stall");
    for (int i = 0; i < 4; i++) begin
      tick(1'b0);
      if (i == 2) chk(pending == 1, "R7 pending during stall", pending, 1);
      tick(1'b0);
      tick(1'b1);
    end
    repeat (2) tick(1'b0);

    // R3: negative displacement wraps
    send(1'b0, 1'b0, 1'b1, 1'b0, 24'h00FFE0, 24'h000010, 1'b1, 24'hFFFFF3, "R3 neg disp");
    for (int i = 0; i < 4; i++) tick(1'b1);
    repeat (2) tick(1'b0);

    // R4 + R5: GE form with N set -> not taken
    send(1'b1, 1'b1, 1'b0, 1'b0, 24'h123456, 24'h000200, 1'b0, '0, "R4 R5 ge not taken");
    for (int i = 0; i < 6; i++) tick(1'b1);
    chk(pending == 0, "R5 still idle", pending, 0);
    chk(issue_ready == 1, "R5 ready stays", issue_ready, 1);

    // R4 + R8 + R9: GE taken, then flags/pc change and a second issue mid-delay
    send(1'b1, 1'b0, 1'b0, 1'b0, 24'h55AA55, 24'h000300, 1'b1, 24'h55AA55, "R8 R9 ge taken");
    tick(1'b1);
    chk(issue_ready == 0, "R9 busy not ready", issue_ready, 0);
    issue_valid = 1'b1; cond_sel = 1'b0; n_flag = 1'b1; rel_mode = 1'b1;
    operand = 24'h000777; pc = 24'h000999;
    tick(1'b1);
    issue_valid = 1'b0;
    tick(1'b0);
    tick(1'b1);
    tick(1'b1);
    repeat (6) tick(1'b1);
    chk(pending == 0, "R9 dropped issue left no pending", pending, 0);

    // R10: block-repeat form hands over to loop check
    send(1'b0, 1'b0, 1'b1, 1'b1, 24'h000004, 24'h000400, 1'b1, 24'h000407, "R10 block rpt");
    for (int i = 0; i < 4; i++) tick(1'b1);
    repeat (3) tick(1'b0);

    chk(sb.size() == 0, "R11 every taken branch completed once", sb.size(), 0);
    done_flag = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done_flag) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule